// File: doc/BRIEF.md
# Double-Buffered Timer PWM Generator

This block drives one pulse-width-modulated output with up to 10 bits of duty resolution. Its time base is 10 bits wide. An 8-bit timer forms the upper part and a 2-bit fine count forms the lower part. A selectable prescaler sets how many clocks each fine-count step lasts: 1, 4 or 16. The timer runs from zero up to a host-written period limit and then wraps. One output period therefore lasts (limit + 1) × 4 × prescale clocks.

The host writes a 10-bit duty value into a buffer register. The value in the buffer reaches the active compare register only at a period boundary, so a write never alters the pulse that is already running. At each boundary the output rises, and it falls when the time base reaches the active duty. A zero duty keeps the output low. A duty beyond the end of the period keeps the output high. Dropping the enable clears the time base and forces the output low. After enable returns, the output stays low until the first boundary.

Top module: `pwm_gen`

## Requirements
- R1: While reset is asserted the output is 0. After reset, and while `enable` is 0, the output stays 0 regardless of the register writes.
- R2: `preSel` encodes the clocks per fine step: 2'b00 gives 1, 2'b01 gives 4, and 2'b10 or 2'b11 give 16. The rise-to-rise output period is (period + 1) × 4 × step clocks.
- R3: The time base is {timer[7:0], fine[1:0]}. When it stands at {period, 2'b11} and the next step occurs, the timer clears to 0 and the output rises in that cycle, provided the active duty is non-zero.
- R4: The output falls in the cycle in which the time base reaches the active duty. The high time is therefore duty × step clocks. Duty bits [9:2] match the timer and bits [1:0] match the fine count.
- R5: A duty write during a period does not change the high time of that period. The buffered value becomes active at the next boundary.
- R6: If a duty write falls in the same cycle as a boundary, the active duty takes the value the buffer held before the write. The new value becomes active one period later.
- R7: An active duty of 0 keeps the output low for the whole period.
- R8: An active duty greater than 4 × period + 3 keeps the output high through every period.
- R9: When `enable` goes low, the output is 0 from the next cycle and the timer, fine count and prescaler clear. When `enable` returns, the output stays low until the first boundary, which comes (period + 1) × 4 × step clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run enable; low clears the time base and forces the output low |
| preSel | input | 2 | Prescale select (1, 4 or 16 clocks per fine step) |
| periodWr | input | 1 | Write strobe for the period limit |
| periodData | input | 8 | Period limit value |
| dutyWr | input | 1 | Write strobe for the duty buffer |
| dutyData | input | 10 | Duty value, upper 8 bits timer compare, lower 2 bits fine compare |
| pwmOut | output | 1 | PWM output |

## Verification
A host write into the duty buffer and the buffer-to-active copy at a period boundary can fall on the same clock edge. The bench's reference model flags, one half cycle ahead, the edge on which the boundary will occur. The bench then strobes a new duty for exactly that edge. The high time of the period that follows must show the old buffer value, and the period after it must show the new value. The model is also compared with the output on every clock, so a wrong choice shows up at once.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int TIMER_BITS = 8;
  localparam int FINE_BITS  = 2;
  localparam int PRE_LOG    = 2;

  // Control-to-datapath strobes
  typedef struct packed {
    logic run;    // time base is counting
    logic carry;  // fine count wraps on this edge, timer advances
  } pwmStrobe_t;

endpackage

// File: rtl/pwm_control.sv
module pwm_control
  import pwm_pkg::*;
#(
  parameter int FINE_W = FINE_BITS,
  parameter int PRE_L  = PRE_LOG
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        preSel,
  output logic [FINE_W-1:0] fineCnt,
  output pwmStrobe_t        strobe
);

  localparam int PRE_W = 2 * PRE_L;
  localparam logic [FINE_W-1:0] FINE_MAX = '1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic             tick;

  // Last prescaler count before a fine step
  always_comb begin
    case (preSel)
      2'b00:   preLimit = '0;
      2'b01:   preLimit = PRE_W'((1 << PRE_L) - 1);
      default: preLimit = '1;
    endcase
  end

  assign tick = (preCnt >= preLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (!enable || tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fineCnt <= '0;
    end else if (!enable) begin
      fineCnt <= '0;
    end else if (tick) begin
      fineCnt <= fineCnt + 1'b1;
    end
  end

  assign strobe.run   = enable;
  assign strobe.carry = enable && tick && (fineCnt == FINE_MAX);

  AST_FINE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !tick) |=> $stable(fineCnt)); // R2

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (fineCnt == '0 && preCnt == '0)); // R9

endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int TMR_W  = TIMER_BITS,
  parameter int FINE_W = FINE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwmStrobe_t        strobe,
  input  logic [FINE_W-1:0] fineCnt,
  input  logic              periodWr,
  input  logic [TMR_W-1:0]  periodData,
  input  logic              dutyWr,
  input  logic [TMR_W+FINE_W-1:0] dutyData,
  output logic              pwmOut
);

  localparam int DUTY_W = TMR_W + FINE_W;

  logic [TMR_W-1:0]  periodReg;
  logic [TMR_W-1:0]  timerCnt;
  logic [DUTY_W-1:0] masterDuty;
  logic [DUTY_W-1:0] slaveDuty;
  logic [DUTY_W-1:0] timeBase;
  logic              armed;
  logic              boundary;

  assign boundary = strobe.carry && (timerCnt == periodReg);
  assign timeBase = {timerCnt, fineCnt};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg <= '0;
    end else if (periodWr) begin
      periodReg <= periodData;
    end
  end

  // Host-side duty buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterDuty <= '0;
    end else if (dutyWr) begin
      masterDuty <= dutyData;
    end
  end

  // Active compare value, loaded only at a period boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slaveDuty <= '0;
    end else if (boundary) begin
      slaveDuty <= masterDuty;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerCnt <= '0;
    end else if (!strobe.run || boundary) begin
      timerCnt <= '0;
    end else if (strobe.carry) begin
      timerCnt <= timerCnt + 1'b1;
    end
  end

  // Set at the first boundary after enable, cleared when idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (!strobe.run) begin
      armed <= 1'b0;
    end else if (boundary) begin
      armed <= 1'b1;
    end
  end

  assign pwmOut = armed && (timeBase < slaveDuty);

  AST_SLAVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |=> $stable(slaveDuty)); // R5

  AST_SLAVE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    boundary |=> (slaveDuty == $past(masterDuty))); // R6

  AST_WRAP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    boundary |=> (timerCnt == '0)); // R3

  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (slaveDuty == '0) |-> !pwmOut); // R7

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |=> !pwmOut); // R9

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
#(
  parameter int TMR_W  = TIMER_BITS,
  parameter int FINE_W = FINE_BITS,
  parameter int PRE_L  = PRE_LOG
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic [1:0]              preSel,
  input  logic                    periodWr,
  input  logic [TMR_W-1:0]        periodData,
  input  logic                    dutyWr,
  input  logic [TMR_W+FINE_W-1:0] dutyData,
  output logic                    pwmOut
);

  pwmStrobe_t        strobe;
  logic [FINE_W-1:0] fineCnt;

  pwm_control #(
    .FINE_W (FINE_W),
    .PRE_L  (PRE_L)
  ) uControl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .preSel  (preSel),
    .fineCnt (fineCnt),
    .strobe  (strobe)
  );

  pwm_datapath #(
    .TMR_W  (TMR_W),
    .FINE_W (FINE_W)
  ) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fineCnt    (fineCnt),
    .periodWr   (periodWr),
    .periodData (periodData),
    .dutyWr     (dutyWr),
    .dutyData   (dutyData),
    .pwmOut     (pwmOut)
  );

endmodule

// File: tb/tb_pwm_gen.sv
`timescale 1ns/1ps
module tb_pwm_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] preSel = 2'b00;
  logic       periodWr = 1'b0;
  logic [7:0] periodData = '0;
  logic       dutyWr = 1'b0;
  logic [9:0] dutyData = '0;
  logic       pwmOut;

  int checks = 0;
  int errors = 0;
  string curTag = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  pwm_gen dut (
    .clk(clk), .rstN(rstN), .enable(enable), .preSel(preSel),
    .periodWr(periodWr), .periodData(periodData),
    .dutyWr(dutyWr), .dutyData(dutyData), .pwmOut(pwmOut)
  );

  // Behavioural reference model
  int mPre = 0, mFine = 0, mTmr = 0, mPer = 0, mMaster = 0, mSlave = 0;
  bit mArmed = 0;

  function automatic int stepOf(input logic [1:0] s);
    if (s == 2'b00) return 1;
    if (s == 2'b01) return 4;
    return 16;
  endfunction

  function automatic bit bdyNext();
    return enable && (mPre >= stepOf(preSel) - 1) && (mFine == 3) && (mTmr == mPer);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPre = 0; mFine = 0; mTmr = 0; mPer = 0; mMaster = 0; mSlave = 0; mArmed = 0;
    end else begin
      int oldMaster;
      int oldPer;
      oldMaster = mMaster;
      oldPer = mPer;
      if (dutyWr) mMaster = dutyData;
      if (periodWr) mPer = periodData;
      if (!enable) begin
        mPre = 0; mFine = 0; mTmr = 0; mArmed = 0;
      end else if (mPre >= stepOf(preSel) - 1) begin
        mPre = 0;
        if (mFine == 3) begin
          mFine = 0;
          if (mTmr == oldPer) begin
            mTmr = 0; mSlave = oldMaster; mArmed = 1;
          end else begin
            mTmr = (mTmr + 1) % 256;
          end
        end else begin
          mFine = mFine + 1;
        end
      end else begin
        mPre = mPre + 1;
      end
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      bit expOut;
      expOut = mArmed && ((mTmr * 4 + mFine) < mSlave);
      checks++;
      if (pwmOut !== expOut) begin
        errors++;
        $display("FAIL %s model compare at %0t: actual %0b expected %0b",
                 curTag, $time, pwmOut, expOut);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic writePeriod(input int v);
    @(negedge clk); periodWr = 1'b1; periodData = 8'(v);
    @(negedge clk); periodWr = 1'b0;
  endtask

  task automatic writeDuty(input int v);
    @(negedge clk); dutyWr = 1'b1; dutyData = 10'(v);
    @(negedge clk); dutyWr = 1'b0;
  endtask

  // Measures high samples and rise-to-rise samples of one period.
  // synced=1 means the current sample is already a rising sample.
  task automatic measure(input bit synced, output int hi, output int per);
    logic last;
    if (!synced) begin
      @(negedge clk); last = pwmOut;
      forever begin
        @(negedge clk);
        if (pwmOut && !last) break;
        last = pwmOut;
      end
    end
    hi = 1; per = 1; last = 1'b1;
    forever begin
      @(negedge clk);
      if (pwmOut && !last) break;
      if (pwmOut) hi++;
      per++;
      last = pwmOut;
    end
  endtask

  task automatic countHigh(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwmOut) hi++;
    end
  endtask

  task automatic setPrescale(input logic [1:0] s);
    @(negedge clk); enable = 1'b0;
    @(negedge clk); preSel = s;
    @(negedge clk); enable = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi, per, lows;
    // R1: reset state and idle behaviour
    curTag = "R1";
    repeat (3) @(negedge clk);
    chk("R1 output low in reset", pwmOut, 0);
    rstN = 1'b1;
    writePeriod(9);
    writeDuty(17);
    countHigh(30, hi);
    chk("R1 output low while disabled", hi, 0);

    // R3 R4: basic waveform, step 1, period 40
    curTag = "R3";
    @(negedge clk); enable = 1'b1;
    measure(0, hi, per);
    chk("R4 high time duty 17 step 1", hi, 17);
    chk("R3 period limit 9 step 1", per, 40);
    curTag = "R4";
    writeDuty(38);
    measure(0, hi, per);
    measure(1, hi, per);
    chk("R4 high time duty 38 (fine bits 10)", hi, 38);

    // R2: prescale steps
    curTag = "R2";
    writeDuty(17);
    setPrescale(2'b01);
    measure(0, hi, per);
    measure(1, hi, per);
    chk("R2 high time step 4", hi, 68);
    chk("R2 period step 4", per, 160);
    setPrescale(2'b10);
    measure(0, hi, per);
    chk("R2 high time step 16 sel 10", hi, 272);
    chk("R2 period step 16 sel 10", per, 640);
    writePeriod(1);
    writeDuty(5);
    setPrescale(2'b11);
    measure(0, hi, per);
    measure(1, hi, per);
    chk("R2 high time step 16 sel 11", hi, 80);
    chk("R2 period step 16 sel 11", per, 128);

    // R5: write in mid period
    curTag = "R5";
    writePeriod(9);
    writeDuty(17);
    setPrescale(2'b00);
    measure(0, hi, per);
    measure(1, hi, per);
    fork
      measure(1, hi, per);
      begin repeat (3) @(negedge clk); writeDuty(30); end
    join
    chk("R5 mid-period write leaves current high time", hi, 17);
    measure(1, hi, per);
    chk("R5 new duty active next period", hi, 30);

    // R6: write on the boundary edge
    curTag = "R6";
    measure(0, hi, per);
    do @(negedge clk); while (!bdyNext());
    dutyWr = 1'b1; dutyData = 10'd8;
    @(negedge clk); dutyWr = 1'b0;
    measure(1, hi, per);
    chk("R6 boundary write: old buffer used", hi, 30);
    measure(1, hi, per);
    chk("R6 boundary write: new value one period later", hi, 8);

    // R9: disable and re-enable
    curTag = "R9";
    measure(0, hi, per);
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    chk("R9 output low after disable", pwmOut, 0);
    repeat (5) @(negedge clk);
    enable = 1'b1;
    lows = 0;
    forever begin
      @(negedge clk);
      if (pwmOut) break;
      lows++;
    end
    chk("R9 low samples before first boundary", lows, 39);
    measure(1, hi, per);
    chk("R9 high time after re-enable", hi, 8);

    // R7: zero duty
    curTag = "R7";
    writeDuty(0);
    repeat (80) @(negedge clk);
    countHigh(80, hi);
    chk("R7 zero duty stays low", hi, 0);

    // R8: duty beyond period
    curTag = "R8";
    writeDuty(1023);
    repeat (80) @(negedge clk);
    countHigh(80, hi);
    chk("R8 oversize duty stays high", hi, 80);
    writeDuty(40);
    repeat (80) @(negedge clk);
    countHigh(80, hi);
    chk("R8 duty 40 equals period length, stays high", hi, 80);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule